// File: doc/BRIEF.md
# Root Hub Downstream Port Status and Control Register

This block keeps the state of one downstream port of a USB host controller root hub and shows it as a single 32-bit word. A read returns three live status bits: device connected, port enabled and port suspended. It also returns four sticky change flags, which software clears by writing 1 to them. A write uses the same low bit positions as command strobes. Writing 1 to the connected-bit position disables the port. Writing 1 to the enabled-bit position enables it. Writing 1 to the suspended-bit position suspends it. Writing 0 to any position has no effect.

The port logic drives a level that shows whether a device is attached. It also drives single-cycle pulses for overcurrent, port power switched off, babble or bus error, reset completion and resume completion. A static strap marks the attached device as fixed, so the port always reads as connected. If software tries to enable or suspend a port that has no device, the command is refused and the connect-change flag is raised. Hardware events take priority over software writes to the same bit. The port can never be enabled while it reads as disconnected.

Top module: `usb_rh_port_reg`

## Requirements
- R1: Reset clears every stored bit. While reset is held, and on the first read after it with no device and no strap, the word reads 0. All bits other than 0, 1, 2, 16, 17, 18 and 20 always read 0.
- R2: Bit 0 (connected) equals the attach input sampled at the previous clock edge, and no write ever changes it. Each change of that sampled value sets bit 16 (connect change). This includes the first sample after reset when a device is present.
- R3: While the strap is high, bit 0 reads 1 in the same cycle, and attach or detach changes set no flag.
- R4: Writing 1 to bit 1 while bit 0 reads 1 sets bit 1 (enabled). Writing 0 there changes nothing.
- R5: Writing 1 to bit 1 or bit 2 while bit 0 reads 0 leaves bits 1 and 2 clear and sets bit 16.
- R6: Writing 1 to bit 0 clears bit 1. When bit 0 and bit 1 are both written with 1 in the same write, the port ends up disabled.
- R7: Writing 1 to bit 2 while bit 0 reads 1 sets bit 2 (suspended).
- R8: An overcurrent, power-off or bus-error pulse clears bit 1. If bit 1 was set, the pulse also sets bit 17 (enable change).
- R9: A detach clears bits 1 and 2 and sets bit 16. It also sets bit 17 if the port was enabled.
- R10: A reset-completion pulse clears bit 2 and sets bit 20 (reset change). It also sets bit 1 if bit 0 reads 1 and no fault or detach arrives in the same cycle.
- R11: A resume-completion pulse clears bit 2 and sets bit 18 (suspend change). It sets bit 1 under the same condition as in R10.
- R12: Writing 1 to bit 16, 17, 18 or 20 clears that flag. When a hardware event sets the same flag in the same cycle, the flag stays set.
- R13: Bit 1 never reads 1 while bit 0 reads 0. When a hardware event and a software write act on the same bit in one cycle, the hardware event decides the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for wr_data |
| wr_data | input | 32 | Command and clear-flag bits |
| rd_data | output | 32 | Status and change word |
| dev_attached | input | 1 | Level from the port logic: a device is present |
| nonremovable | input | 1 | Strap: the device is fixed and always connected |
| ev_overcurrent | input | 1 | Overcurrent pulse |
| ev_power_off | input | 1 | Port power switched off pulse |
| ev_bus_error | input | 1 | Babble or bus error pulse |
| ev_reset_done | input | 1 | Port reset finished pulse |
| ev_resume_done | input | 1 | Resume from suspend finished pulse |

## Verification
Every stored result is due exactly one clock edge after the cycle that carries its write or event. The read word is formed combinationally from those registers. The only exception is the strap, which forces bit 0 in the same cycle. The bench drives each cycle's inputs just after a falling edge and lets the rising edge capture them. It advances its own model of the register at that rising edge. It then compares the whole 32-bit word at the next falling edge, so no check ever samples on the same edge that updates the state.

// File: rtl/usb_rh_port_pkg.sv
package usb_rh_port_pkg;

  localparam int unsigned REG_W   = 32;
  localparam int unsigned CCS_BIT = 0;
  localparam int unsigned PES_BIT = 1;
  localparam int unsigned PSS_BIT = 2;
  localparam int unsigned NUM_CHG = 4;

  typedef enum logic [1:0] {
    CHG_CONN = 2'd0,
    CHG_EN   = 2'd1,
    CHG_SUSP = 2'd2,
    CHG_RST  = 2'd3
  } chg_idx_e;

  // bit position of each sticky change flag in the register word
  function automatic int unsigned chg_pos(input int unsigned idx);
    case (idx)
      0:       return 16;
      1:       return 17;
      2:       return 18;
      default: return 20;
    endcase
  endfunction

  // sticky flag: a hardware set beats a software clear
  function automatic logic sticky_next(input logic q, input logic set, input logic clr);
    return set | (q & ~clr);
  endfunction

  function automatic logic [REG_W-1:0] pack_word(input logic ccs, input logic pes,
                                                 input logic pss,
                                                 input logic [NUM_CHG-1:0] chg);
    logic [REG_W-1:0] w;
    w = '0;
    w[CCS_BIT] = ccs;
    w[PES_BIT] = pes;
    w[PSS_BIT] = pss;
    for (int i = 0; i < NUM_CHG; i++) w[chg_pos(i)] = chg[i];
    return w;
  endfunction

endpackage

// File: rtl/rh_conn_track.sv
module rh_conn_track (
  input  logic clk,
  input  logic rst_n,
  input  logic dev_attached,
  input  logic nonremovable,
  output logic ccs,
  output logic attach_ev,
  output logic detach_ev
);
  logic link_now;
  logic link_q;

  assign link_now = dev_attached | nonremovable;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) link_q <= 1'b0;
    else        link_q <= link_now;
  end

  // a fixed device always reads as present and raises no events
  assign ccs       = link_q | nonremovable;
  assign attach_ev = link_now & ~link_q & ~nonremovable;
  assign detach_ev = ~link_now & link_q;
endmodule

// File: rtl/rh_port_state.sv
module rh_port_state (
  input  logic clk,
  input  logic rst_n,
  input  logic ccs,
  input  logic detach_ev,
  input  logic fault_ev,
  input  logic reset_done,
  input  logic resume_done,
  input  logic cmd_clr_en,
  input  logic cmd_set_en,
  input  logic cmd_set_susp,
  output logic pes,
  output logic pss,
  output logic pes_hw_drop,
  output logic cmd_refused
);
  logic pes_q, pss_q, pes_d, pss_d;
  logic hw_clr, hw_set, susp_end;

  assign hw_clr   = fault_ev | detach_ev;
  assign hw_set   = reset_done | resume_done;
  assign susp_end = detach_ev | reset_done | resume_done;

  always_comb begin
    // priority: hardware clear, hardware set, disable, enable, hold
    if (!ccs || hw_clr)  pes_d = 1'b0;
    else if (hw_set)     pes_d = 1'b1;
    else if (cmd_clr_en) pes_d = 1'b0;
    else if (cmd_set_en) pes_d = 1'b1;
    else                 pes_d = pes_q;

    if (susp_end)                pss_d = 1'b0;
    else if (cmd_set_susp && ccs) pss_d = 1'b1;
    else                         pss_d = pss_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pes_q <= 1'b0;
      pss_q <= 1'b0;
    end else begin
      pes_q <= pes_d;
      pss_q <= pss_d;
    end
  end

  assign pes         = pes_q;
  assign pss         = pss_q;
  assign pes_hw_drop = pes_q & hw_clr;
  assign cmd_refused = ~ccs & (cmd_set_en | cmd_set_susp);
endmodule

// File: rtl/rh_change_bit.sv
module rh_change_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= usb_rh_port_pkg::sticky_next(q, set, clr);
  end
endmodule

// File: rtl/usb_rh_port_reg.sv
module usb_rh_port_reg
  import usb_rh_port_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic             dev_attached,
  input  logic             nonremovable,
  input  logic             ev_overcurrent,
  input  logic             ev_power_off,
  input  logic             ev_bus_error,
  input  logic             ev_reset_done,
  input  logic             ev_resume_done
);
  logic ccs, attach_ev, detach_ev, fault_any;
  logic pes, pss, pes_hw_drop, cmd_refused;
  logic cmd_clr_en, cmd_set_en, cmd_set_susp;
  logic [NUM_CHG-1:0] chg_set, chg_clr, chg_q;

  assign fault_any    = ev_overcurrent | ev_power_off | ev_bus_error;
  assign cmd_clr_en   = wr_en & wr_data[CCS_BIT];
  assign cmd_set_en   = wr_en & wr_data[PES_BIT];
  assign cmd_set_susp = wr_en & wr_data[PSS_BIT];

  rh_conn_track u_conn (
    .clk          (clk),
    .rst_n        (rst_n),
    .dev_attached (dev_attached),
    .nonremovable (nonremovable),
    .ccs          (ccs),
    .attach_ev    (attach_ev),
    .detach_ev    (detach_ev)
  );

  rh_port_state u_state (
    .clk          (clk),
    .rst_n        (rst_n),
    .ccs          (ccs),
    .detach_ev    (detach_ev),
    .fault_ev     (fault_any),
    .reset_done   (ev_reset_done),
    .resume_done  (ev_resume_done),
    .cmd_clr_en   (cmd_clr_en),
    .cmd_set_en   (cmd_set_en),
    .cmd_set_susp (cmd_set_susp),
    .pes          (pes),
    .pss          (pss),
    .pes_hw_drop  (pes_hw_drop),
    .cmd_refused  (cmd_refused)
  );

  assign chg_set[CHG_CONN] = attach_ev | detach_ev | cmd_refused;
  assign chg_set[CHG_EN]   = pes_hw_drop;
  assign chg_set[CHG_SUSP] = ev_resume_done;
  assign chg_set[CHG_RST]  = ev_reset_done;

  for (genvar gi = 0; gi < NUM_CHG; gi++) begin : g_chg
    assign chg_clr[gi] = wr_en & wr_data[chg_pos(gi)];
    rh_change_bit u_bit (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (chg_set[gi]),
      .clr   (chg_clr[gi]),
      .q     (chg_q[gi])
    );
  end

  assign rd_data = pack_word(ccs, pes, pss, chg_q);
endmodule

// File: rtl/usb_rh_port_reg_chk.sv
module usb_rh_port_reg_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [31:0] wr_data,
  input logic [31:0] rd_data,
  input logic        dev_attached,
  input logic        nonremovable,
  input logic        fault_any,
  input logic        detach_ev,
  input logic        reset_done
);
  // R13
  enable_needs_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[1] |-> rd_data[0]);

  // R3
  fixed_dev_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nonremovable |-> rd_data[0]);

  // R2
  link_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (nonremovable || rd_data[0] == $past(dev_attached | nonremovable)));

  // R5
  refuse_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[1] && !rd_data[0]) |=> (rd_data[16] && !rd_data[1]));

  // R8
  fault_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_any && rd_data[1]) |=> (!rd_data[1] && rd_data[17]));

  // R10
  reset_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reset_done && rd_data[0] && !fault_any && !detach_ev)
      |=> (rd_data[1] && rd_data[20] && !rd_data[2]));

  // R12
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[20] && !reset_done) |=> !rd_data[20]);
endmodule

bind usb_rh_port_reg usb_rh_port_reg_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .wr_en        (wr_en),
  .wr_data      (wr_data),
  .rd_data      (rd_data),
  .dev_attached (dev_attached),
  .nonremovable (nonremovable),
  .fault_any    (fault_any),
  .detach_ev    (detach_ev),
  .reset_done   (ev_reset_done)
);

// File: tb/usb_rh_port_reg_tb.sv
`timescale 1ns/1ps
module usb_rh_port_reg_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        dev_attached = 1'b0, nonremovable = 1'b0;
  logic        ev_overcurrent = 1'b0, ev_power_off = 1'b0, ev_bus_error = 1'b0;
  logic        ev_reset_done = 1'b0, ev_resume_done = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [6:0] st = '0; // {rst_chg, susp_chg, en_chg, conn_chg, susp, en, link_sample}

  always #2 clk = ~clk;

  usb_rh_port_reg u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .dev_attached(dev_attached), .nonremovable(nonremovable),
    .ev_overcurrent(ev_overcurrent), .ev_power_off(ev_power_off),
    .ev_bus_error(ev_bus_error), .ev_reset_done(ev_reset_done),
    .ev_resume_done(ev_resume_done)
  );

  function automatic logic [31:0] expect_word(input logic [6:0] s, input logic strap);
    logic [31:0] w = '0;
    w[0] = s[0] | strap; w[1] = s[1]; w[2] = s[2];
    w[16] = s[3]; w[17] = s[4]; w[18] = s[5]; w[20] = s[6];
    return w;
  endfunction

  function automatic logic [6:0] model_next(input logic [6:0] s, input logic strap,
      input logic att, input logic flt, input logic rstd, input logic rsmd,
      input logic we, input logic [31:0] wd);
    logic [6:0] n;
    logic seen, now, gone, moved, fault, w_off, w_on, w_sus;
    seen  = s[0] | strap;
    now   = att | strap;
    moved = !strap && (now != s[0]);
    gone  = !strap && s[0] && !now;
    fault = flt || gone;
    w_off = we && wd[0]; w_on = we && wd[1]; w_sus = we && wd[2];
    n[0] = now;
    if (!seen || fault)    n[1] = 1'b0;
    else if (rstd || rsmd) n[1] = 1'b1;
    else if (w_off)        n[1] = 1'b0;
    else if (w_on)         n[1] = 1'b1;
    else                   n[1] = s[1];
    if (gone || rstd || rsmd) n[2] = 1'b0;
    else if (w_sus && seen)   n[2] = 1'b1;
    else                      n[2] = s[2];
    n[3] = (moved || (!seen && (w_on || w_sus))) ? 1'b1 : ((we && wd[16]) ? 1'b0 : s[3]);
    n[4] = (s[1] && fault) ? 1'b1 : ((we && wd[17]) ? 1'b0 : s[4]);
    n[5] = rsmd ? 1'b1 : ((we && wd[18]) ? 1'b0 : s[5]);
    n[6] = rstd ? 1'b1 : ((we && wd[20]) ? 1'b0 : s[6]);
    return n;
  endfunction

  task automatic check(input string tag, input logic [31:0] exp);
    checks++;
    if (rd_data !== exp) begin
      errors++;
      $display("FAIL %s: rd_data=%08h expected=%08h", tag, rd_data, exp);
    end
  endtask

  // drive one cycle just after a falling edge, compare at the next falling edge
  task automatic step(input string tag, input logic att, input logic strap,
      input logic [2:0] flt, input logic rstd, input logic rsmd,
      input logic we, input logic [31:0] wd);
    dev_attached = att; nonremovable = strap;
    ev_overcurrent = flt[0]; ev_power_off = flt[1]; ev_bus_error = flt[2];
    ev_reset_done = rstd; ev_resume_done = rsmd;
    wr_en = we; wr_data = wd;
    @(posedge clk);
    st = model_next(st, strap, att, |flt, rstd, rsmd, we, wd);
    @(negedge clk);
    check(tag, expect_word(st, strap));
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    check("R1 word during reset", 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    step("R1 idle after reset",               0, 0, 3'b000, 0, 0, 0, 32'h0);
    step("R5 enable refused when unplugged",  0, 0, 3'b000, 0, 0, 1, 32'h2);
    step("R12 clear connect flag",            0, 0, 3'b000, 0, 0, 1, 32'h0001_0000);
    step("R2 attach raises flag",             1, 0, 3'b000, 0, 0, 0, 32'h0);
    step("R4 write of zero ignored",          1, 0, 3'b000, 0, 0, 1, 32'h0);
    step("R4 enable command",                 1, 0, 3'b000, 0, 0, 1, 32'h2);
    step("R7 suspend command",                1, 0, 3'b000, 0, 0, 1, 32'h4);
    step("R6 disable beats enable",           1, 0, 3'b000, 0, 0, 1, 32'h3);
    step("R4 enable again",                   1, 0, 3'b000, 0, 0, 1, 32'h2);
    step("R8 overcurrent drops enable",       1, 0, 3'b001, 0, 0, 0, 32'h0);
    step("R8 power off on disabled port",     1, 0, 3'b010, 0, 0, 0, 32'h0);
    step("R10 reset end enables",             1, 0, 3'b000, 1, 0, 0, 32'h0);
    step("R12 set wins over clear",           1, 0, 3'b000, 1, 0, 1, 32'h0010_0000);
    step("R13 reset end loses to bus error",  1, 0, 3'b100, 1, 0, 1, 32'h2);
    step("R4 enable after error",             1, 0, 3'b000, 0, 0, 1, 32'h2);
    step("R7 suspend again",                  1, 0, 3'b000, 0, 0, 1, 32'h4);
    step("R11 resume end",                    1, 0, 3'b000, 0, 1, 0, 32'h0);
    step("R12 clear all flags",               1, 0, 3'b000, 0, 0, 1, 32'h0017_0000);
    step("R2 write cannot change link bit",   1, 0, 3'b000, 0, 0, 1, 32'h1);
    step("R4 enable before detach",           1, 0, 3'b000, 0, 0, 1, 32'h6);
    step("R9 detach",                         0, 0, 3'b000, 0, 0, 0, 32'h0);
    step("R5 suspend refused when unplugged", 0, 0, 3'b000, 0, 0, 1, 32'h0001_0004);
    step("R3 strap forces link",              0, 1, 3'b000, 0, 0, 1, 32'h0003_0000);
    step("R3 strap allows enable, no event",  0, 1, 3'b000, 0, 0, 1, 32'h2);
    step("R3 attach under strap no flag",     1, 1, 3'b000, 0, 0, 0, 32'h0);
    void'($urandom(32'h5eed_0042));
    for (int i = 0; i < 3000; i++) begin
      logic att, strap, we;
      logic [2:0] flt;
      logic [31:0] wd;
      att   = ($urandom % 24 == 0) ? ~dev_attached : dev_attached;
      strap = ($urandom % 300 == 0) ? ~nonremovable : nonremovable;
      flt   = {($urandom % 20 == 0), ($urandom % 25 == 0), ($urandom % 20 == 0)};
      we    = ($urandom % 3 == 0);
      wd    = $urandom;
      if ($urandom % 2 == 0) wd = wd & 32'h0017_0007;
      step("R13 random against model", att, strap, flt,
           ($urandom % 18 == 0), ($urandom % 18 == 0), we, wd);
    end
    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule